// File: doc/BRIEF.md
# Bus Cycle Ready Generator

This block produces the ready indication that ends a processor bus cycle. The ready line is active low and open drain, so the block does not drive a level. It has a single output, `rdy_pull_low`, which asks for the line to be pulled down. An external resistor, which the testbench models, pulls the line high whenever the block lets go. Every clock edge of `clk` stands for one sampling edge of the system clock.

The block takes ready from two qualified sources:

- **Synchronous source.** A ready input and its enable, sampled as they are.
- **Asynchronous source.** A ready input and its enable, which must first pass through a two-stage synchronizer.

Both sources are looked at only while the peripheral clock phase input `pclk` is high. A bus status line sampled low marks the start of a bus cycle and releases the line for a fixed window, so the pull-up can restore it.

The block also takes a raw active-low reset input and turns it into an active-high system reset through a two-stage synchronizer. While that reset is active, the ready request is forced on.

The controller is a six-state machine:

| State | Line | Meaning |
| --- | --- | --- |
| `ST_IDLE` | released | Waiting for a qualified ready source. |
| `ST_REL1` | released | First cycle of the release window. |
| `ST_REL2` | released | Second cycle of the release window. |
| `ST_ASSERT1` | pulled low | First asserted cycle. |
| `ST_HOLD` | pulled low | Held until the owning source drops or a status line falls. |
| `ST_RSTRDY` | pulled low | Forced on by reset. |

Transitions, all taken at the sampling edge:

- **reset**: any state goes to `ST_RSTRDY` while the system reset is active.
- **start**: a status line sampled low in `ST_IDLE`, `ST_REL1`, `ST_REL2`, `ST_HOLD` or `ST_RSTRDY` (once reset is inactive) goes to `ST_REL1`.
- **wait**: `ST_REL1` goes to `ST_REL2`, and `ST_REL2` goes to `ST_IDLE`.
- **grant**: `ST_IDLE` with a qualified source goes to `ST_ASSERT1`. The owning source is recorded here.
- **extend**: `ST_ASSERT1` always goes to `ST_HOLD`.
- **drop**: `ST_HOLD` goes to `ST_IDLE` when the owning source is sampled inactive.

Top module: `bus_ready_gen`

## Requirements
- R1: `rst_out` equals the inverse of `rst_in_n` as sampled two clock edges earlier.
- R2: One edge after `rst_out` is sampled high, `rdy_pull_low` is 1. After reset ends it stays 1 until a status line (`stat0_n` or `stat1_n`) is sampled at 0.
- R3: In the idle state, a sampled edge with `stat0_n`=1, `stat1_n`=1, `pclk`=1, `sync_rdy_n`=0 and `sync_en_n`=0 sets `rdy_pull_low` to 1 at that edge.
- R4: While idle, the synchronous pair has no effect if `pclk` is 0 or if either status line is 0. In that case `rdy_pull_low` stays 0.
- R5: The asynchronous pair (`async_rdy_n`=0 and `async_en_n`=0) is seen through two flip-flops. It grants ready only at an edge with `pclk`=1, and no earlier than the third edge after the pair becomes active.
- R6: When a grant finds the synchronized asynchronous pair active, the asynchronous source owns the cycle. The synchronous inputs are then ignored until the cycle ends.
- R7: A status line sampled at 0 at edge k (other than in the first asserted cycle) makes `rdy_pull_low` 0 after edges k, k+1 and k+2.
- R8: Once `rdy_pull_low` rises, it stays 1 for at least two clock cycles.
- R9: After its first cycle, an asserted ready ends when the owning source is sampled inactive with `pclk`=1. For the synchronous source, both status lines must also be 1 at that edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Sampling clock; each rising edge models a system clock sampling edge |
| rst_in_n | input | 1 | Raw reset request, active low, asynchronous to clk |
| stat0_n | input | 1 | Bus status line 0, active low |
| stat1_n | input | 1 | Bus status line 1, active low |
| pclk | input | 1 | Peripheral clock phase; ready sources are qualified only while high |
| sync_rdy_n | input | 1 | Synchronous ready, active low |
| sync_en_n | input | 1 | Enable for the synchronous ready, active low |
| async_rdy_n | input | 1 | Asynchronous ready, active low |
| async_en_n | input | 1 | Enable for the asynchronous ready, active low |
| rst_out | output | 1 | Synchronized system reset, active high |
| rdy_pull_low | output | 1 | Request to pull the open-drain ready line low |

## Verification
The grant logic is driven with four kinds of input pattern:

- **Synchronous-only requests.** These show that the status and `pclk` qualification is applied.
- **Asynchronous-only requests.** These show the two-flop latency and the forced wait state.
- **Both sources active together, then the synchronous pair withdrawn.** This tells asynchronous ownership apart from a plain OR of the two sources.
- **Status pulses landing in every state.** These show that the three-edge release window restarts correctly and that the two-cycle minimum takes precedence over a status edge.

A long constrained-random run then mixes all of these with irregular `pclk` phases, and a bench model predicts every cycle.

// File: rtl/rgen_pkg.sv
package rgen_pkg;

    // Controller states; encoding value of ST_IDLE is the power-up value.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REL1    = 3'd1,
        ST_REL2    = 3'd2,
        ST_ASSERT1 = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RSTRDY  = 3'd5
    } rgen_state_t;

    // Which source owns the current ready assertion.
    typedef enum logic {
        SRC_SYNC  = 1'b0,
        SRC_ASYNC = 1'b1
    } rgen_src_t;

endpackage

// File: rtl/rgen_sync.sv
module rgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= d;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/rgen_qualify.sv
module rgen_qualify (
    input  logic status_hi,
    input  logic pclk,
    input  logic sync_rdy_n,
    input  logic sync_en_n,
    input  logic async_act_s,
    output logic sync_hit,
    output logic async_hit,
    output logic sync_drop,
    output logic async_drop
);
    logic sync_pair_act;
    logic sync_window;

    always_comb begin
        sync_pair_act = ~sync_rdy_n & ~sync_en_n;
        sync_window   = status_hi & pclk;
        sync_hit      = sync_window & sync_pair_act;
        sync_drop     = sync_window & ~sync_pair_act;
        async_hit     = pclk & async_act_s;
        async_drop    = pclk & ~async_act_s;
    end
endmodule

// File: rtl/rgen_fsm.sv
module rgen_fsm
    import rgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic status_low,
    input  logic pclk,
    input  logic sync_hit,
    input  logic async_hit,
    input  logic sync_drop,
    input  logic async_drop,
    output logic drive_low
);
    rgen_state_t state_q, state_d;
    rgen_src_t   src_q, src_d;
    logic        owner_drop;

    always_comb begin
        owner_drop = (src_q == SRC_ASYNC) ? async_drop : sync_drop;
        state_d    = state_q;
        src_d      = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (status_low) begin
                    state_d = ST_REL1;
                end else if (async_hit) begin
                    state_d = ST_ASSERT1;
                    src_d   = SRC_ASYNC;
                end else if (sync_hit) begin
                    state_d = ST_ASSERT1;
                    src_d   = SRC_SYNC;
                end
            end
            ST_REL1:    state_d = status_low ? ST_REL1 : ST_REL2;
            ST_REL2:    state_d = status_low ? ST_REL1 : ST_IDLE;
            ST_ASSERT1: state_d = ST_HOLD;
            ST_HOLD: begin
                if (status_low)      state_d = ST_REL1;
                else if (owner_drop) state_d = ST_IDLE;
            end
            ST_RSTRDY:  state_d = status_low ? ST_REL1 : ST_RSTRDY;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RSTRDY;
            src_q   <= SRC_SYNC;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ASSERT1, ST_HOLD, ST_RSTRDY: drive_low = 1'b1;
            default:                        drive_low = 1'b0;
        endcase
    end

    p_min_two_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |=> drive_low);

    p_release_first_r7: assert property (@(posedge clk) disable iff (rst)
        (status_low && state_q != ST_ASSERT1) |=> !drive_low);

    p_release_second_r7: assert property (@(posedge clk) disable iff (rst)
        (status_low && state_q != ST_ASSERT1) |=> ##1 !drive_low);

    p_idle_pclk_low_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !pclk) |=> !drive_low);

    p_async_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && src_q == SRC_ASYNC && !status_low && !async_drop)
            |=> drive_low);
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen #(
    parameter int RST_STAGES   = 2,
    parameter int ASYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    input  logic stat0_n,
    input  logic stat1_n,
    input  logic pclk,
    input  logic sync_rdy_n,
    input  logic sync_en_n,
    input  logic async_rdy_n,
    input  logic async_en_n,
    output logic rst_out,
    output logic rdy_pull_low
);
    logic status_low;
    logic async_act_raw;
    logic async_act_s;
    logic sync_hit, async_hit, sync_drop, async_drop;

    assign status_low    = ~stat0_n | ~stat1_n;
    assign async_act_raw = ~async_rdy_n & ~async_en_n;

    rgen_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk (clk),
        .d   (~rst_in_n),
        .q   (rst_out)
    );

    rgen_sync #(.STAGES(ASYNC_STAGES)) u_async_sync (
        .clk (clk),
        .d   (async_act_raw),
        .q   (async_act_s)
    );

    rgen_qualify u_qual (
        .status_hi   (~status_low),
        .pclk        (pclk),
        .sync_rdy_n  (sync_rdy_n),
        .sync_en_n   (sync_en_n),
        .async_act_s (async_act_s),
        .sync_hit    (sync_hit),
        .async_hit   (async_hit),
        .sync_drop   (sync_drop),
        .async_drop  (async_drop)
    );

    rgen_fsm u_fsm (
        .clk        (clk),
        .rst        (rst_out),
        .status_low (status_low),
        .pclk       (pclk),
        .sync_hit   (sync_hit),
        .async_hit  (async_hit),
        .sync_drop  (sync_drop),
        .async_drop (async_drop),
        .drive_low  (rdy_pull_low)
    );

    p_rst_assert_r1: assert property (@(posedge clk) disable iff (1'b0)
        !rst_in_n |=> ##1 rst_out);

    p_rst_force_r2: assert property (@(posedge clk) disable iff (!rst_in_n)
        rst_out |=> rdy_pull_low);
endmodule

// File: tb/tb_bus_ready_gen.sv
module tb_bus_ready_gen;
    logic clk = 1'b0;
    logic rst_in_n = 1'b0;
    logic stat0_n = 1'b1, stat1_n = 1'b1, pclk = 1'b0;
    logic sync_rdy_n = 1'b1, sync_en_n = 1'b1;
    logic async_rdy_n = 1'b1, async_en_n = 1'b1;
    logic rst_out, rdy_pull_low;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_ready_gen dut (
        .clk(clk), .rst_in_n(rst_in_n), .stat0_n(stat0_n), .stat1_n(stat1_n),
        .pclk(pclk), .sync_rdy_n(sync_rdy_n), .sync_en_n(sync_en_n),
        .async_rdy_n(async_rdy_n), .async_en_n(async_en_n),
        .rst_out(rst_out), .rdy_pull_low(rdy_pull_low)
    );

    // Reference state derived from the requirements.
    bit    m_r1 = 0, m_rst = 0, m_a1 = 0, m_a2 = 0;
    bit    m_drive = 0, m_forced = 0, m_own_async = 0;
    int    m_age = 0, m_rel = 0;
    string m_tag = "R4";

    task automatic model_step();
        bit sl, ahit, shit, aact, old_rst;
        sl      = !stat0_n || !stat1_n;
        ahit    = pclk && m_a2;
        shit    = stat0_n && stat1_n && pclk && !sync_rdy_n && !sync_en_n;
        aact    = !async_rdy_n && !async_en_n;
        old_rst = m_rst;
        m_tag   = "R4";
        if (old_rst) begin
            m_forced = 1; m_drive = 1; m_rel = 0; m_age = 0; m_tag = "R2";
        end else if (m_forced) begin
            if (sl) begin m_forced = 0; m_drive = 0; m_rel = 2; m_tag = "R7"; end
            else m_tag = "R2";
        end else if (m_drive) begin
            if (m_age == 1) begin m_age = 2; m_tag = "R8"; end
            else if (sl) begin m_drive = 0; m_rel = 2; m_tag = "R7"; end
            else if (m_own_async) begin
                if (pclk && !m_a2) begin m_drive = 0; m_tag = "R9"; end
                else m_tag = "R6";
            end else begin
                if (stat0_n && stat1_n && pclk && (sync_rdy_n || sync_en_n)) m_drive = 0;
                m_tag = "R9";
            end
        end else begin
            if (sl) begin m_rel = 2; m_tag = "R7"; end
            else if (m_rel > 0) begin m_rel--; m_tag = "R7"; end
            else if (ahit) begin m_drive = 1; m_age = 1; m_own_async = 1; m_tag = "R5"; end
            else if (shit) begin m_drive = 1; m_age = 1; m_own_async = 0; m_tag = "R3"; end
        end
        m_rst = m_r1;
        m_r1  = !rst_in_n;
        m_a2  = m_a1;
        m_a1  = aact;
    endtask

    function automatic bit line_level(bit pull);
        return pull ? 1'b0 : 1'b1;  // resistive pull-up unless pulled low
    endfunction

    task automatic check_bit(string tag, bit act, bit exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: edge, model, then compare and drive at the falling edge.
    task automatic cycle(bit s0, bit s1, bit pc, bit sr, bit se, bit ar, bit ae);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_bit("R1", rst_out, m_rst, "rst_out");
        check_bit(m_tag, rdy_pull_low, m_drive, "rdy_pull_low");
        if (m_rel > 0)
            check_bit("R7", line_level(rdy_pull_low), 1'b1, "line level in release window");
        stat0_n = s0; stat1_n = s1; pclk = pc;
        sync_rdy_n = sr; sync_en_n = se; async_rdy_n = ar; async_en_n = ae;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        bit pc;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        // R1/R2: reset held, then released
        for (int i = 0; i < 6; i++) cycle(1, 1, i[0], 1, 1, 1, 1);
        rst_in_n = 1'b1;
        for (int i = 0; i < 4; i++) cycle(1, 1, i[0], 1, 1, 1, 1);
        check_bit("R2", rdy_pull_low, 1'b1, "forced ready after reset");
        // R7: status pulse releases the line
        cycle(0, 1, 0, 1, 1, 1, 1);
        for (int i = 0; i < 4; i++) cycle(1, 1, i[0], 1, 1, 1, 1);
        check_bit("R7", rdy_pull_low, 1'b0, "released after status pulse");
        // R4: sync pair with pclk low, then status low
        cycle(1, 1, 0, 0, 0, 1, 1);
        cycle(1, 1, 0, 0, 0, 1, 1);
        check_bit("R4", rdy_pull_low, 1'b0, "sync pair ignored with pclk low");
        // R3/R8/R9: sync grant then drop
        cycle(1, 1, 1, 0, 0, 1, 1);
        cycle(1, 1, 0, 1, 1, 1, 1);
        check_bit("R3", rdy_pull_low, 1'b1, "sync grant");
        cycle(1, 1, 1, 1, 1, 1, 1);
        check_bit("R8", rdy_pull_low, 1'b1, "second asserted cycle");
        cycle(1, 1, 0, 1, 1, 1, 1);
        check_bit("R9", rdy_pull_low, 1'b0, "sync drop");
        // R5/R6: async and sync together, sync withdrawn
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 1, 1, 0, 0);
        check_bit("R5", rdy_pull_low, 1'b0, "async wait state");
        cycle(1, 1, 1, 1, 1, 0, 0);
        cycle(1, 1, 0, 1, 1, 0, 0);
        cycle(1, 1, 1, 1, 1, 0, 0);
        cycle(1, 1, 0, 1, 1, 0, 0);
        cycle(1, 1, 1, 1, 1, 0, 0);
        check_bit("R6", rdy_pull_low, 1'b1, "async owner held despite sync inactive");
        for (int i = 0; i < 6; i++) cycle(1, 1, i[0], 1, 1, 1, 1);
        // Random phase
        pc = 0;
        for (int i = 0; i < 4000; i++) begin
            bit s0, s1;
            if (($urandom % 5) != 0) pc = ~pc;
            s0 = (($urandom % 10) != 0);
            s1 = (($urandom % 10) != 0);
            cycle(s0, s1, pc, ($urandom % 3) == 0 ? 1'b1 : 1'b0, $urandom % 2 == 0,
                  $urandom % 3 == 0, $urandom % 4 == 0);
            if (i == 2000) rst_in_n = 1'b0;
            if (i == 2008) rst_in_n = 1'b1;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule